// File: doc/BRIEF.md
# Precise Exception Pipeline Tracker

This block is the exception-control spine of a five-stage in-order pipeline with fetch, decode, execute, memory and write-back stages. Each of the five stage slots holds a valid bit, the program counter of the instruction it carries, and a small fault cause field. Fault detectors in the first four stages report faults by pulsing a one-bit input. The tracker records each fault quietly in the instruction's own cause field and acts on it only when that instruction reaches write-back. Because of this, faults are taken in program order, whatever their order in time.

When an instruction with a recorded fault sits in write-back, the tracker takes the exception. In that cycle it squashes the four younger slots, blocks the memory write of the instruction in the memory stage, and latches the faulting PC and its cause. In the next cycle it points the fetch PC at a fixed handler address. An instruction that has faulted is treated as a no-op from then on: its register-file write and its memory write are withheld. A stall input freezes the whole pipeline. The tracker owns the fetch PC, which advances by a fixed step for each instruction fetched.

Top module: `exc_pipe_tracker`

## Requirements
- R1: After reset all slots are empty, `fetch_pc` equals `RESET_PC`, `take_exc` is low, and `exc_pc` and `exc_cause` are zero.
- R2: In each cycle without stall and with `fetch_en` high, a new instruction enters the fetch slot with PC equal to `fetch_pc`, and `fetch_pc` then increases by `PC_STEP`. Without a stall, an instruction reaches write-back (`wb_valid`, `wb_pc`) four clock edges after it enters.
- R3: Cause codes are 1 for a fetch fault (`flt_if`), 2 for a decode fault (`flt_id`), 3 for an execute fault (`flt_ex`) and 4 for a memory-stage fault (`flt_me`), with 0 meaning no fault. Only the first fault of an instruction is kept; a fault reported for it in a later stage does not change the code.
- R4: `take_exc` is high exactly in an unstalled cycle in which write-back holds a valid instruction with a nonzero cause. The oldest faulting instruction is taken first, even when a younger one faulted earlier in time.
- R5: While `take_exc` is high, `flush_younger` is all ones. In the next cycle every slot is empty.
- R6: One edge after `take_exc`, `exc_pc` holds the faulting instruction's PC and `exc_cause` holds its cause code.
- R7: One edge after `take_exc`, `fetch_pc` equals `HANDLER_VEC`. Fetch then continues from that address.
- R8: An instruction with a recorded fault never asserts `rf_we` in write-back and never asserts `mem_we` in the memory stage. This includes the cycle in which its memory-stage fault is reported.
- R9: `mem_we` is low in any cycle in which `take_exc` is high, even for a clean store in the memory stage.
- R10: Faults reported for empty slots are ignored and never lead to an exception.
- R11: While `stall` is high, every slot's PC and cause and `fetch_pc` hold their values. Faults reported during the stall are ignored, and no write enable or exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes all pipeline slots and the fetch PC |
| fetch_en | input | 1 | An instruction is fetched at `fetch_pc` this cycle |
| flt_if | input | 1 | Fault on the instruction in the fetch slot |
| flt_id | input | 1 | Fault on the instruction in the decode slot |
| flt_ex | input | 1 | Fault on the instruction in the execute slot |
| flt_me | input | 1 | Fault on the instruction in the memory slot |
| me_store | input | 1 | The memory-stage instruction wants to write memory |
| wb_wr | input | 1 | The write-back instruction wants to write a register |
| fetch_pc | output | PC_W | Current fetch address |
| take_exc | output | 1 | Exception taken this cycle |
| flush_younger | output | 4 | Squash for the fetch, decode, execute and memory slots (bit 0 = fetch) |
| exc_pc | output | PC_W | PC saved at the last exception |
| exc_cause | output | 3 | Cause code saved at the last exception |
| rf_we | output | 1 | Register-file write permitted for the write-back instruction |
| mem_we | output | 1 | Memory write permitted for the memory-stage instruction |
| wb_valid | output | 1 | Write-back slot holds an instruction |
| wb_pc | output | PC_W | PC of the write-back instruction |

## Verification
The bench builds the tracker with a 16-bit PC, a reset PC of 0x0100, a handler vector of 0x0800 and a step of 4. With these values, saved PCs and redirects can be told apart at a glance, and a handler redirect can never be confused with the sequential stream. The short PC still keeps the fetch address well clear of wrap-around over the run. The vector walk mixes stalls, bubbles and faults in all four stages. This brings within reach the hard orderings: a younger instruction faulting before an older one, a second fault on an already-faulted instruction, a stall that holds a faulting instruction in write-back, and a clean store that meets an exception in the same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    C_NONE   = 3'd0,
    C_IFETCH = 3'd1,
    C_ILLOP  = 3'd2,
    C_OVF    = 3'd3,
    C_DFETCH = 3'd4
  } cause_e;

  localparam int N_FSTAGE = 4;

  function automatic cause_e stage_code(input int s);
    case (s)
      0:       return C_IFETCH;
      1:       return C_ILLOP;
      2:       return C_OVF;
      default: return C_DFETCH;
    endcase
  endfunction

  // A recorded cause wins; otherwise a live slot takes the new fault code.
  function automatic cause_e first_fault(input cause_e held, input logic live,
                                         input logic hit, input cause_e code);
    if (held != C_NONE) return held;
    if (live && hit) return code;
    return C_NONE;
  endfunction

endpackage

// File: rtl/exc_slot_stage.sv
module exc_slot_stage
  import exc_pkg::*;
#(
  parameter int     PC_W = 32,
  parameter cause_e CODE = C_IFETCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            squash,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  cause_e          in_cause,
  input  logic            fault,
  output logic            q_valid,
  output logic [PC_W-1:0] q_pc,
  output cause_e          q_cause,
  output cause_e          eff_cause
);

  always_ff @(posedge clk) begin
    if (!rst_n || squash) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_cause <= C_NONE;
    end else if (advance) begin
      q_valid <= in_valid;
      q_pc    <= in_pc;
      q_cause <= in_cause;
    end
  end

  // Faults seen while stalled are dropped so the held status stays put.
  assign eff_cause = first_fault(q_cause, q_valid, fault & advance, CODE);

endmodule

// File: rtl/exc_fetch_pc.sv
module exc_fetch_pc #(
  parameter int              PC_W        = 32,
  parameter logic [PC_W-1:0] RESET_PC    = '0,
  parameter logic [PC_W-1:0] HANDLER_VEC = '0,
  parameter int              PC_STEP     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            fetch_en,
  input  logic            redirect,
  output logic [PC_W-1:0] pc_q
);

  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  function automatic logic [PC_W-1:0] next_pc(input logic [PC_W-1:0] cur,
                                              input logic go, input logic redir);
    if (redir) return HANDLER_VEC;
    if (go) return cur + STEP_V;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= next_pc(pc_q, advance & fetch_en, redirect);
  end

endmodule

// File: rtl/exc_retire.sv
module exc_retire
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            me_valid,
  input  logic [PC_W-1:0] me_pc,
  input  cause_e          me_cause,
  input  logic            me_store,
  input  logic            wb_wr,
  output logic            wb_valid,
  output logic [PC_W-1:0] wb_pc,
  output cause_e          wb_cause,
  output logic            take,
  output logic            rf_we,
  output logic            mem_we,
  output logic [PC_W-1:0] exc_pc,
  output cause_e          exc_cause
);

  logic wb_faulted;
  logic wb_clean;

  assign wb_faulted = wb_valid && (wb_cause != C_NONE);
  assign wb_clean   = wb_valid && (wb_cause == C_NONE);
  assign take       = wb_faulted && advance;
  assign rf_we      = wb_wr && wb_clean && advance;
  assign mem_we     = me_store && me_valid && (me_cause == C_NONE) && advance && !take;

  always_ff @(posedge clk) begin
    if (!rst_n || take) begin
      wb_valid <= 1'b0;
      wb_pc    <= '0;
      wb_cause <= C_NONE;
    end else if (advance) begin
      wb_valid <= me_valid;
      wb_pc    <= me_pc;
      wb_cause <= me_cause;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_pc    <= '0;
      exc_cause <= C_NONE;
    end else if (take) begin
      exc_pc    <= wb_pc;
      exc_cause <= wb_cause;
    end
  end

endmodule

// File: rtl/exc_pipe_tracker.sv
module exc_pipe_tracker
  import exc_pkg::*;
#(
  parameter int              PC_W        = 32,
  parameter logic [PC_W-1:0] RESET_PC    = '0,
  parameter logic [PC_W-1:0] HANDLER_VEC = PC_W'(32'h0000_0180),
  parameter int              PC_STEP     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            fetch_en,
  input  logic            flt_if,
  input  logic            flt_id,
  input  logic            flt_ex,
  input  logic            flt_me,
  input  logic            me_store,
  input  logic            wb_wr,
  output logic [PC_W-1:0] fetch_pc,
  output logic            take_exc,
  output logic [3:0]      flush_younger,
  output logic [PC_W-1:0] exc_pc,
  output logic [2:0]      exc_cause,
  output logic            rf_we,
  output logic            mem_we,
  output logic            wb_valid,
  output logic [PC_W-1:0] wb_pc
);

  localparam int LAST = N_FSTAGE - 1;

  logic                advance;
  logic [N_FSTAGE-1:0] flt_vec;
  logic                st_v   [N_FSTAGE];
  logic [PC_W-1:0]     st_pc  [N_FSTAGE];
  cause_e              st_c   [N_FSTAGE];
  cause_e              st_e   [N_FSTAGE];
  logic                in_v   [N_FSTAGE];
  logic [PC_W-1:0]     in_pc  [N_FSTAGE];
  cause_e              in_c   [N_FSTAGE];
  cause_e              wb_cause_w;
  cause_e              exc_cause_w;

  assign advance = !stall;
  assign flt_vec = {flt_me, flt_ex, flt_id, flt_if};

  exc_fetch_pc #(
    .PC_W(PC_W), .RESET_PC(RESET_PC), .HANDLER_VEC(HANDLER_VEC), .PC_STEP(PC_STEP)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .advance(advance), .fetch_en(fetch_en),
    .redirect(take_exc), .pc_q(fetch_pc)
  );

  for (genvar s = 0; s < N_FSTAGE; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign in_v[s]  = fetch_en;
      assign in_pc[s] = fetch_pc;
      assign in_c[s]  = C_NONE;
    end else begin : g_link
      assign in_v[s]  = st_v[s-1];
      assign in_pc[s] = st_pc[s-1];
      assign in_c[s]  = st_e[s-1];
    end

    exc_slot_stage #(.PC_W(PC_W), .CODE(stage_code(s))) u_slot (
      .clk(clk), .rst_n(rst_n), .advance(advance), .squash(take_exc),
      .in_valid(in_v[s]), .in_pc(in_pc[s]), .in_cause(in_c[s]),
      .fault(flt_vec[s]),
      .q_valid(st_v[s]), .q_pc(st_pc[s]), .q_cause(st_c[s]), .eff_cause(st_e[s])
    );
  end

  exc_retire #(.PC_W(PC_W)) u_retire (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .me_valid(st_v[LAST]), .me_pc(st_pc[LAST]), .me_cause(st_e[LAST]),
    .me_store(me_store), .wb_wr(wb_wr),
    .wb_valid(wb_valid), .wb_pc(wb_pc), .wb_cause(wb_cause_w),
    .take(take_exc), .rf_we(rf_we), .mem_we(mem_we),
    .exc_pc(exc_pc), .exc_cause(exc_cause_w)
  );

  assign exc_cause     = exc_cause_w;
  assign flush_younger = {N_FSTAGE{take_exc}};

endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk #(
  parameter int              PC_W        = 32,
  parameter logic [PC_W-1:0] HANDLER_VEC = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall,
  input logic            take_exc,
  input logic            rf_we,
  input logic            mem_we,
  input logic            wb_valid,
  input logic [PC_W-1:0] wb_pc,
  input logic [2:0]      wb_cause,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] exc_pc,
  input logic [2:0]      exc_cause
);

  a_r4_take_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> (wb_valid && wb_cause != 3'd0 && !stall));

  a_r5_squash_all: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> !wb_valid);

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (exc_pc == $past(wb_pc) && exc_cause == $past(wb_cause)));

  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (fetch_pc == HANDLER_VEC));

  a_r8_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> !rf_we);

  a_r9_store_block: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> !mem_we);

  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetch_pc));

endmodule

bind exc_pipe_tracker exc_tracker_chk #(.PC_W(PC_W), .HANDLER_VEC(HANDLER_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .take_exc(take_exc),
  .rf_we(rf_we), .mem_we(mem_we), .wb_valid(wb_valid), .wb_pc(wb_pc),
  .wb_cause(wb_cause_w), .fetch_pc(fetch_pc), .exc_pc(exc_pc), .exc_cause(exc_cause)
);

// File: tb/sim_exc_pipe_tracker.sv
module sim_exc_pipe_tracker;

  localparam int          PW    = 16;
  localparam logic [15:0] RST_A = 16'h0100;
  localparam logic [15:0] HVEC  = 16'h0800;
  localparam int          STEP  = 4;

  // {stall, fetch_en, flt_me, flt_ex, flt_id, flt_if, wb_wr, me_store}
  localparam int NV = 40;
  localparam logic [7:0] VEC [NV] = '{
    8'b01000011, 8'b01000011, 8'b01000011, 8'b01000011, 8'b01000011,
    8'b01000011, 8'b01001011, 8'b01000011, 8'b01000111, 8'b01010011,
    8'b01000011, 8'b01000011, 8'b01000011, 8'b01000011, 8'b01000011,
    8'b00000011, 8'b01000111, 8'b01000011, 8'b11111111, 8'b11000011,
    8'b01000011, 8'b01100011, 8'b01000011, 8'b01000011, 8'b01000011,
    8'b01000011, 8'b00111101, 8'b00000011, 8'b01000011, 8'b01000011,
    8'b01000101, 8'b01001011, 8'b01010011, 8'b01100011, 8'b11000011,
    8'b01000011, 8'b01000011, 8'b01000011, 8'b01000011, 8'b01000011
  };

  logic clk = 1'b0;
  logic rst_n;
  logic stall, fetch_en, flt_if, flt_id, flt_ex, flt_me, me_store, wb_wr;
  logic [PW-1:0] fetch_pc, exc_pc, wb_pc;
  logic          take_exc, rf_we, mem_we, wb_valid;
  logic [3:0]    flush_younger;
  logic [2:0]    exc_cause;

  int checks = 0;
  int errors = 0;

  // Independent model of the slot contents
  logic          mv [5];
  logic [PW-1:0] mpc [5];
  int            mc [5];
  logic [PW-1:0] mfpc, mepc;
  int            mcause;

  always #4 clk = ~clk;

  exc_pipe_tracker #(.PC_W(PW), .RESET_PC(RST_A), .HANDLER_VEC(HVEC), .PC_STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_en(fetch_en),
    .flt_if(flt_if), .flt_id(flt_id), .flt_ex(flt_ex), .flt_me(flt_me),
    .me_store(me_store), .wb_wr(wb_wr), .fetch_pc(fetch_pc), .take_exc(take_exc),
    .flush_younger(flush_younger), .exc_pc(exc_pc), .exc_cause(exc_cause),
    .rf_we(rf_we), .mem_we(mem_we), .wb_valid(wb_valid), .wb_pc(wb_pc)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {stall, fetch_en, flt_me, flt_ex, flt_id, flt_if, wb_wr, me_store} = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(8'h00);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 5; s++) begin mv[s] = 1'b0; mpc[s] = '0; mc[s] = 0; end
    mfpc = RST_A; mepc = '0; mcause = 0;
  endtask

  // One cycle: drive at the falling edge, check, then advance the model on the rising edge
  task automatic step(input logic [7:0] v, input string ttag);
    int  e [4];
    logic adv, tk, rfw, mw;
    logic [3:0] fl;
    @(negedge clk);
    drive(v);
    #1;
    adv = !v[7];
    fl  = v[5:2];
    for (int s = 0; s < 4; s++) begin
      if (mc[s] != 0) e[s] = mc[s];
      else if (mv[s] && fl[s] && adv) e[s] = s + 1;
      else e[s] = 0;
    end
    tk  = mv[4] && (mc[4] != 0) && adv;
    rfw = v[1] && mv[4] && (mc[4] == 0) && adv;
    mw  = v[0] && mv[3] && (e[3] == 0) && adv && !tk;
    chk(ttag, 32'(take_exc), 32'(tk));
    chk("R5 flush", 32'(flush_younger), tk ? 32'hF : 32'h0);
    chk("R8 rf_we", 32'(rf_we), 32'(rfw));
    chk("R9 mem_we", 32'(mem_we), 32'(mw));
    chk("R2 fetch_pc", 32'(fetch_pc), 32'(mfpc));
    chk("R2 wb_valid", 32'(wb_valid), 32'(mv[4]));
    if (mv[4]) chk("R2 wb_pc", 32'(wb_pc), 32'(mpc[4]));
    chk("R6 exc_pc", 32'(exc_pc), 32'(mepc));
    chk("R6 exc_cause", 32'(exc_cause), 32'(mcause));
    @(posedge clk);
    if (tk) begin
      mepc = mpc[4]; mcause = mc[4];
      for (int s = 0; s < 5; s++) begin mv[s] = 1'b0; mc[s] = 0; end
      mfpc = HVEC;
    end else if (adv) begin
      for (int s = 4; s > 0; s--) begin
        mv[s] = mv[s-1]; mpc[s] = mpc[s-1]; mc[s] = e[s-1];
      end
      mv[0] = v[6]; mpc[0] = mfpc; mc[0] = 0;
      if (v[6]) mfpc = mfpc + 16'(STEP);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(8'h00);
    do_reset();
    #1;
    // R1: reset state
    chk("R1 fetch_pc", 32'(fetch_pc), 32'(RST_A));
    chk("R1 wb_valid", 32'(wb_valid), 0);
    chk("R1 take_exc", 32'(take_exc), 0);
    chk("R1 exc_cause", 32'(exc_cause), 0);
    chk("R1 exc_pc", 32'(exc_pc), 0);

    // Vector walk
    for (int i = 0; i < NV; i++) step(VEC[i], "R4 take");

    // R3: first fault kept; later stage faults on the same instruction ignored
    do_reset();
    step(8'b01000000, "R4 take");   // I0 enters fetch
    step(8'b01000000, "R4 take");   // I0 in decode
    step(8'b01001000, "R4 take");   // decode fault on I0 (code 2)
    step(8'b01010000, "R4 take");   // execute fault on I0 ignored
    step(8'b01100001, "R8 take");   // memory fault ignored, store of I0 withheld
    chk("R8 mem_we faulted", 32'(mem_we), 0);
    step(8'b01000011, "R4 take");   // I0 in WB: take, clean I1 store blocked (R9)
    #2;
    chk("R3 exc_cause", 32'(exc_cause), 2);
    chk("R6 exc_pc", 32'(exc_pc), 32'(RST_A));
    chk("R7 handler", 32'(fetch_pc), 32'(HVEC));
    chk("R5 slots empty", 32'(wb_valid), 0);
    step(8'b01000000, "R7 take");
    #2;
    chk("R7 step after handler", 32'(fetch_pc), 32'(HVEC) + STEP);

    // R4: younger fault earlier in time, older fault later; older is taken
    do_reset();
    step(8'b01000000, "R4 take");
    step(8'b01000000, "R4 take");
    step(8'b01000100, "R4 take");   // I1 fetch fault while I0 in decode
    step(8'b01000000, "R4 take");
    step(8'b01100000, "R4 take");   // I0 memory fault
    step(8'b00000000, "R4 take");   // I0 taken
    #2;
    chk("R4 order cause", 32'(exc_cause), 4);
    chk("R4 order pc", 32'(exc_pc), 32'(RST_A));

    // R10: faults on empty slots
    do_reset();
    for (int k = 0; k < 8; k++) step(8'b00111100, "R10 take");
    chk("R10 no exception", 32'(exc_cause), 0);

    // R11: stall holds status and fetch PC; faults during stall ignored
    do_reset();
    step(8'b01000000, "R4 take");
    step(8'b01000000, "R4 take");
    for (int k = 0; k < 4; k++) step(8'b10111111, "R11 take");
    chk("R11 fetch_pc held", 32'(fetch_pc), 32'(RST_A) + 2 * STEP);
    for (int k = 0; k < 4; k++) step(8'b00000011, "R11 take");
    chk("R11 retired clean", 32'(exc_cause), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule